// File: doc/BRIEF.md
# LCD Timing Controller with Staged Enable

This block generates the timing for a parallel-RGB display. A small write-only register bank holds the per-axis sync width, porches and active size. It also holds a pixel-clock divisor with a source select, the sync polarities and an output-format code. From these settings the block produces:

- a pixel clock enable,
- horizontal and vertical sync,
- a data-enable strobe,
- a one-cycle start-of-vertical-blank pulse,
- the current pixel position.

The block has three stages: the pixel clock, sync generation and the display data enable. Each stage has its own enable strobe and its own disable strobe. A status vector reports which stages are running. Software brings the stages up in the order pixel clock, sync, display. It waits for each status bit to set before it enables the next stage, and it tears the stages down in the reverse order. The block refuses any strobe that breaks this order.

Top module: `lcd_tc`

## Requirements
- R1: After synchronous reset, `stage_on` is 0, `pix_ce`, `de`, `vblank`, `hsync` and `vsync` are 0, the pixel position is (0,0) and `out_fmt` is 0.
- R2: The geometry words are encoded as follows.
  - Address 1 holds the hsync width minus one in bits 15:0 and the vsync width minus one in bits 31:16.
  - Address 2 holds the vertical front porch minus one in bits 15:0 and the vertical back porch with no offset in bits 31:16.
  - Address 3 holds the horizontal front porch minus one in bits 15:0 and the horizontal back porch minus one in bits 31:16.
  - Address 4 holds the active width minus one in bits 15:0 and the active height minus one in bits 31:16.
  - Each axis runs in the order sync, back porch, active, front porch.
  - `pos_x` and `pos_y` report the position of the pixel currently shown.
- R3: Address 0 holds the divisor in bits 7:0 and the source select in bit 16. Divisor values below 2 act as 2.
  - With the select at 0, `pix_ce` pulses once every divisor cycles.
  - With the select at 1, the source runs at twice the rate, so an even divisor gives one pulse every divisor/2 cycles.
- R4: Bit 0 of address 5 inverts `hsync` and bit 1 inverts `vsync`. With a bit at 0, the pulse is high-going and the idle level is low.
- R5: Bits 9:8 of address 5 appear on `out_fmt`: 0 for 12-bit RGB, 1 for 16-bit, 2 for 18-bit and 3 for 24-bit.
- R6: Strobe bit 0 is the pixel clock, bit 1 is sync and bit 2 is display. An enable strobe is ignored unless the stage below it is already on.
- R7: A disable strobe is ignored while the stage above it is still on.
- R8: An accepted strobe changes its status bit at the next divider tick. A sync disable instead takes effect at the tick that shows the last pixel of the frame.
- R9: While sync is off, `hsync` and `vsync` sit at their idle levels and `de` is 0. `de` is 1 only for active-region pixels shown while the display stage was on.
- R10: `vblank` pulses for one cycle with the pixel at column 0 of the first line after the active lines.
- R11: `pix_ce` pulses only while the pixel clock stage is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 to 5) |
| wr_data | input | 32 | Register write data |
| en_stb | input | 3 | Stage enable strobes |
| dis_stb | input | 3 | Stage disable strobes |
| stage_on | output | 3 | Stage status |
| pix_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| vblank | output | 1 | Start-of-vertical-blank pulse |
| pos_x | output | CW+3 (15) | Column of shown pixel |
| pos_y | output | CW+3 (15) | Line of shown pixel |
| out_fmt | output | 2 | Output format code |

## Verification
The properties rely on every horizontal line holding at least four pixels. The minus-one encoding of sync width, back porch and front porch makes this true for any value written. As a result, the last pixel of a frame always falls in the front porch, and two ticks never both land on column 0. The stimulus issues strobes and register writes only in the cycle between two divider ticks while the divisor is 2, so each change is seen at a known tick. The bench also sweeps whole frames of a small geometry, computing every pixel's expected sync, enable and blank levels from the requirement formulas.

// File: rtl/lcd_tc_pkg.sv
package lcd_tc_pkg;
  localparam int NSTAGE = 3;
  localparam int ST_PCLK = 0;
  localparam int ST_SYNC = 1;
  localparam int ST_DISP = 2;

  localparam logic [2:0] A_CLK  = 3'd0;
  localparam logic [2:0] A_SYNC = 3'd1;
  localparam logic [2:0] A_VPOR = 3'd2;
  localparam logic [2:0] A_HPOR = 3'd3;
  localparam logic [2:0] A_SIZE = 3'd4;
  localparam logic [2:0] A_MODE = 3'd5;

  typedef struct packed {
    logic [15:0] vsw_m1;
    logic [15:0] hsw_m1;
    logic [15:0] vbp;
    logic [15:0] vfp_m1;
    logic [15:0] hbp_m1;
    logic [15:0] hfp_m1;
    logic [15:0] vact_m1;
    logic [15:0] hact_m1;
  } tc_geom_t;
endpackage

// File: rtl/lcd_tc_regs.sv
module lcd_tc_regs
  import lcd_tc_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [2:0]      wr_addr,
  input  logic [31:0]     wr_data,
  output tc_geom_t        geom,
  output logic [DIVW-1:0] div,
  output logic            clk2x,
  output logic            hpol,
  output logic            vpol,
  output logic [1:0]      fmt
);
  logic unused_wd;
  assign unused_wd = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      geom  <= '0;
      div   <= '0;
      clk2x <= 1'b0;
      hpol  <= 1'b0;
      vpol  <= 1'b0;
      fmt   <= 2'd0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CLK: begin
          div   <= wr_data[DIVW-1:0];
          clk2x <= wr_data[16];
        end
        A_SYNC: {geom.vsw_m1, geom.hsw_m1} <= wr_data;
        A_VPOR: {geom.vbp, geom.vfp_m1}    <= wr_data;
        A_HPOR: {geom.hbp_m1, geom.hfp_m1} <= wr_data;
        A_SIZE: {geom.vact_m1, geom.hact_m1} <= wr_data;
        A_MODE: begin
          hpol <= wr_data[0];
          vpol <= wr_data[1];
          fmt  <= wr_data[9:8];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lcd_tc_clkdiv.sv
module lcd_tc_clkdiv #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] div,
  input  logic            clk2x,
  output logic            tick
);
  localparam int AW = DIVW + 1;

  logic [AW-1:0] acc, nxt, divc;

  always_comb begin
    divc = (div < DIVW'(2)) ? AW'(2) : AW'(div);
    nxt  = acc + (clk2x ? AW'(2) : AW'(1));
    tick = (nxt >= divc);
  end

  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (tick) acc <= nxt - divc;
    else           acc <= nxt;
  end
endmodule

// File: rtl/lcd_tc_stages.sv
module lcd_tc_stages #(
  parameter int         N          = 3,
  parameter logic [N-1:0] WAIT_FRAME = 3'b010
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         frame_end,
  input  logic [N-1:0] en_stb,
  input  logic [N-1:0] dis_stb,
  output logic [N-1:0] stat
);
  logic [N-1:0] pend_on, pend_off;

  for (genvar i = 0; i < N; i++) begin : g_st
    logic st_q, pon_q, poff_q, pred_ok, succ_clear, take_on, take_off, hold;

    if (i == 0) begin : g_first
      assign pred_ok = 1'b1;
    end else begin : g_pred
      assign pred_ok = stat[i-1] && !pend_off[i-1];
    end
    if (i == N-1) begin : g_last
      assign succ_clear = 1'b1;
    end else begin : g_succ
      assign succ_clear = !stat[i+1] && !pend_on[i+1];
    end

    assign take_on  = en_stb[i]  && !st_q && pred_ok;
    assign take_off = dis_stb[i] &&  st_q && succ_clear;
    assign hold     = WAIT_FRAME[i] && !frame_end;

    always_ff @(posedge clk) begin
      if (rst) begin
        st_q   <= 1'b0;
        pon_q  <= 1'b0;
        poff_q <= 1'b0;
      end else begin
        if (tick && pon_q) begin
          st_q  <= 1'b1;
          pon_q <= 1'b0;
        end
        if (tick && poff_q && !hold) begin
          st_q   <= 1'b0;
          poff_q <= 1'b0;
        end
        if (take_on) begin
          pon_q  <= 1'b1;
          poff_q <= 1'b0;
        end
        if (take_off) begin
          poff_q <= 1'b1;
          pon_q  <= 1'b0;
        end
      end
    end

    assign stat[i]     = st_q;
    assign pend_on[i]  = pon_q;
    assign pend_off[i] = poff_q;
  end
endmodule

// File: rtl/lcd_tc_timing.sv
module lcd_tc_timing
  import lcd_tc_pkg::*;
#(
  parameter int CW = 12,
  parameter int TW = CW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          sync_on,
  input  logic          disp_on,
  input  tc_geom_t      geom,
  input  logic          hpol,
  input  logic          vpol,
  output logic          frame_end,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          vblank,
  output logic [TW-1:0] pos_x,
  output logic [TW-1:0] pos_y
);
  logic unused_geom;
  assign unused_geom = ^geom;

  logic [TW-1:0] hsw, hbp, hact, hfp, vsw, vbp, vact, vfp;
  logic [TW-1:0] h0, h1, htot, v0, v1, vtot;
  logic [TW-1:0] h, v;
  logic          h_last, v_last, in_act;

  always_comb begin
    hsw  = TW'(geom.hsw_m1[CW-1:0])  + TW'(1);
    hbp  = TW'(geom.hbp_m1[CW-1:0])  + TW'(1);
    hact = TW'(geom.hact_m1[CW-1:0]) + TW'(1);
    hfp  = TW'(geom.hfp_m1[CW-1:0])  + TW'(1);
    vsw  = TW'(geom.vsw_m1[CW-1:0])  + TW'(1);
    vbp  = TW'(geom.vbp[CW-1:0]);
    vact = TW'(geom.vact_m1[CW-1:0]) + TW'(1);
    vfp  = TW'(geom.vfp_m1[CW-1:0])  + TW'(1);
    h0 = hsw + hbp;  h1 = h0 + hact;  htot = h1 + hfp;
    v0 = vsw + vbp;  v1 = v0 + vact;  vtot = v1 + vfp;
    h_last    = (h >= htot - TW'(1));
    v_last    = (v >= vtot - TW'(1));
    frame_end = h_last && v_last;
    in_act    = (h >= h0) && (h < h1) && (v >= v0) && (v < v1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h <= '0;  v <= '0;
      hsync <= 1'b0;  vsync <= 1'b0;
      de <= 1'b0;  vblank <= 1'b0;
      pos_x <= '0;  pos_y <= '0;
    end else begin
      vblank <= 1'b0;
      if (tick) begin
        if (sync_on) begin
          hsync  <= (h < hsw) ^ hpol;
          vsync  <= (v < vsw) ^ vpol;
          de     <= disp_on && in_act;
          vblank <= (h == '0) && (v == v1);
          pos_x  <= h;
          pos_y  <= v;
          if (h_last) begin
            h <= '0;
            v <= v_last ? '0 : v + TW'(1);
          end else begin
            h <= h + TW'(1);
          end
        end else begin
          h <= '0;  v <= '0;
          hsync <= hpol;  vsync <= vpol;
          de <= 1'b0;
          pos_x <= '0;  pos_y <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_tc.sv
module lcd_tc
  import lcd_tc_pkg::*;
#(
  parameter  int CW   = 12,
  parameter  int DIVW = 8,
  localparam int TW   = CW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [2:0]    wr_addr,
  input  logic [31:0]   wr_data,
  input  logic [2:0]    en_stb,
  input  logic [2:0]    dis_stb,
  output logic [2:0]    stage_on,
  output logic          pix_ce,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          vblank,
  output logic [TW-1:0] pos_x,
  output logic [TW-1:0] pos_y,
  output logic [1:0]    out_fmt
);
  tc_geom_t        w_geom;
  logic [DIVW-1:0] w_div;
  logic            w_clk2x, w_hpol, w_vpol, w_tick, w_fend;

  lcd_tc_regs #(.DIVW(DIVW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .geom(w_geom), .div(w_div), .clk2x(w_clk2x), .hpol(w_hpol), .vpol(w_vpol),
    .fmt(out_fmt)
  );

  lcd_tc_clkdiv #(.DIVW(DIVW)) u_div (
    .clk(clk), .rst(rst), .div(w_div), .clk2x(w_clk2x), .tick(w_tick)
  );

  lcd_tc_stages #(.N(NSTAGE), .WAIT_FRAME(3'b010)) u_stages (
    .clk(clk), .rst(rst), .tick(w_tick), .frame_end(w_fend),
    .en_stb(en_stb), .dis_stb(dis_stb), .stat(stage_on)
  );

  lcd_tc_timing #(.CW(CW), .TW(TW)) u_timing (
    .clk(clk), .rst(rst), .tick(w_tick),
    .sync_on(stage_on[ST_SYNC]), .disp_on(stage_on[ST_DISP]),
    .geom(w_geom), .hpol(w_hpol), .vpol(w_vpol), .frame_end(w_fend),
    .hsync(hsync), .vsync(vsync), .de(de), .vblank(vblank),
    .pos_x(pos_x), .pos_y(pos_y)
  );

  always_ff @(posedge clk) begin
    if (rst) pix_ce <= 1'b0;
    else     pix_ce <= w_tick && stage_on[ST_PCLK];
  end
endmodule

// File: rtl/lcd_tc_chk.sv
module lcd_tc_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic [2:0] stat,
  input logic       pix_ce,
  input logic       de,
  input logic       vblank
);
  // R6
  sync_needs_pclk_chk: assert property (@(posedge clk) disable iff (rst)
    stat[1] |-> stat[0]);
  // R6
  disp_needs_sync_chk: assert property (@(posedge clk) disable iff (rst)
    stat[2] |-> stat[1]);
  // R8
  status_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (stat != $past(stat)) |-> $past(tick));
  // R11
  pix_ce_gated_chk: assert property (@(posedge clk) disable iff (rst)
    pix_ce |-> $past(stat[0]));
  // R9
  de_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !stat[1] |-> !de);
  // R9
  de_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(de) |-> $past(stat[2]));
  // R10
  vblank_single_chk: assert property (@(posedge clk) disable iff (rst)
    vblank |=> !vblank);
endmodule

bind lcd_tc lcd_tc_chk u_chk (
  .clk(clk), .rst(rst), .tick(w_tick), .stat(stage_on),
  .pix_ce(pix_ce), .de(de), .vblank(vblank)
);

// File: tb/lcd_tc_bench.sv
module lcd_tc_bench;
  localparam int TW = 15;
  localparam int HSW = 2, HBP = 1, HACT = 4, HFP = 1;
  localparam int VSW = 1, VBP = 1, VACT = 3, VFP = 2;
  localparam int HT = HSW + HBP + HACT + HFP;
  localparam int VT = VSW + VBP + VACT + VFP;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [2:0] wr_addr = '0, en_stb = '0, dis_stb = '0;
  logic [31:0] wr_data = '0;
  logic [2:0] stage_on;
  logic pix_ce, hsync, vsync, de, vblank;
  logic [TW-1:0] pos_x, pos_y;
  logic [1:0] out_fmt;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int ex = 0, ey = 0;
  logic prev_disp = 1'b0, hp = 1'b0, vp = 1'b0, was_last = 1'b0;
  bit done = 0;

  lcd_tc u_lcd_tc (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_stb(en_stb), .dis_stb(dis_stb), .stage_on(stage_on), .pix_ce(pix_ce),
    .hsync(hsync), .vsync(vsync), .de(de), .vblank(vblank),
    .pos_x(pos_x), .pos_y(pos_y), .out_fmt(out_fmt)
  );

  always #5 clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      report();
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic strobe(logic [2:0] en, logic [2:0] dis);
    en_stb = en; dis_stb = dis;
    @(negedge clk);
    en_stb = '0; dis_stb = '0;
  endtask

  // returns the number of negedges waited until pix_ce seen
  task automatic wait_pix(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!pix_ce);
  endtask

  task automatic pix_check();
    int n;
    logic hs, vs, d, vb;
    wait_pix(n);
    hs = (ex < HSW) ^ hp;
    vs = (ey < VSW) ^ vp;
    d  = prev_disp && ex >= HSW + HBP && ex < HSW + HBP + HACT &&
         ey >= VSW + VBP && ey < VSW + VBP + VACT;
    vb = (ex == 0) && (ey == VSW + VBP + VACT);
    // R2 R4 R9 R10: per-pixel sync, enable, blank and position
    chk("R2 R4 R9 R10 pixel", {hsync, vsync, de, vblank, pos_x, pos_y},
        {hs, vs, d, vb, TW'(ex), TW'(ey)});
    was_last  = (ex == HT - 1) && (ey == VT - 1);
    prev_disp = stage_on[2];
    if (ex == HT - 1) begin ex = 0; ey = (ey == VT - 1) ? 0 : ey + 1; end
    else ex++;
  endtask

  task automatic clk_case(logic [7:0] dv, logic sel, int period);
    int n;
    wr(3'd0, {15'd0, sel, 8'd0, dv});
    wait_pix(n); wait_pix(n); wait_pix(n);
    // R3: pulse spacing
    chk("R3 divider period", 64'(n), 64'(period));
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 reset", {stage_on, pix_ce, hsync, vsync, de, vblank, pos_x, pos_y, out_fmt},
        '0);

    wr(3'd0, 32'd2);
    wr(3'd1, (VSW - 1) << 16 | (HSW - 1));
    wr(3'd2, VBP << 16 | (VFP - 1));
    wr(3'd3, (HBP - 1) << 16 | (HFP - 1));
    wr(3'd4, (VACT - 1) << 16 | (HACT - 1));
    wr(3'd5, 32'h200);
    @(negedge clk);
    // R5: format field
    chk("R5 format 2", 64'(out_fmt), 64'd2);

    strobe(3'b010, 3'b000);
    strobe(3'b000, 3'b001);
    repeat (6) @(negedge clk);
    // R6: sync enable refused while pixel clock is off
    chk("R6 early sync enable", 64'(stage_on), 64'd0);
    // R11: no pixel pulses while pixel clock stage is off
    chk("R11 no pix_ce when off", 64'(pix_ce), 64'd0);

    strobe(3'b001, 3'b000);
    n = 0;
    while (!stage_on[0] && n < 4) begin @(negedge clk); n++; end
    // R8: pixel clock status within one tick
    chk("R8 pclk status", 64'(stage_on), 64'd1);
    wait_pix(n);
    wait_pix(n);
    // R3: divisor 2 from system clock
    chk("R3 period 2", 64'(n), 64'd2);

    strobe(3'b100, 3'b000);
    wait_pix(n);
    // R6: display enable refused while sync is off
    chk("R6 early display enable", 64'(stage_on), 64'd1);

    strobe(3'b010, 3'b000);
    wait_pix(n);
    // R8: sync status at next tick
    chk("R8 sync status", 64'(stage_on), 64'd3);
    ex = 0; ey = 0; prev_disp = stage_on[2];

    for (int i = 0; i < HT * VT; i++) pix_check();

    strobe(3'b100, 3'b000);
    pix_check();
    // R8: display status at next tick
    chk("R8 display status", 64'(stage_on), 64'd7);
    for (int i = 0; i < HT * VT + 10; i++) pix_check();

    strobe(3'b000, 3'b010);
    pix_check(); pix_check();
    // R7: sync disable refused while display on
    chk("R7 sync disable refused", 64'(stage_on), 64'd7);
    strobe(3'b000, 3'b001);
    pix_check(); pix_check();
    // R7: pixel clock disable refused while sync on
    chk("R7 pclk disable refused", 64'(stage_on), 64'd7);

    wr(3'd5, 32'h303);
    hp = 1'b1; vp = 1'b1;
    for (int i = 0; i < HT * VT; i++) pix_check();
    // R5: format field updated
    chk("R5 format 3", 64'(out_fmt), 64'd3);

    strobe(3'b000, 3'b100);
    pix_check();
    // R8 R7: display off at next tick
    chk("R8 display off", 64'(stage_on), 64'd3);

    strobe(3'b000, 3'b010);
    was_last = 1'b0;
    for (int i = 0; i < 2 * HT * VT && !was_last; i++) begin
      pix_check();
      // R8: sync stays on until last pixel of frame
      chk("R8 sync off at frame end", 64'(stage_on[1]), 64'(!was_last));
    end
    for (int i = 0; i < 5; i++) begin
      wait_pix(n);
      // R9: idle levels while sync off
      chk("R9 idle outputs", {hsync, vsync, de, vblank}, {hp, vp, 1'b0, 1'b0});
    end

    strobe(3'b000, 3'b001);
    repeat (3) @(negedge clk);
    // R8: pixel clock off
    chk("R8 pclk off", 64'(stage_on), 64'd0);
    n = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (pix_ce) n++; end
    // R11: no pulses after pixel clock stage off
    chk("R11 pix_ce stopped", 64'(n), 64'd0);

    strobe(3'b001, 3'b000);
    clk_case(8'd5, 1'b0, 5);
    clk_case(8'd0, 1'b0, 2);
    clk_case(8'd1, 1'b0, 2);
    clk_case(8'd4, 1'b1, 2);
    clk_case(8'd2, 1'b1, 1);
    clk_case(8'd6, 1'b1, 3);
    clk_case(8'd3, 1'b0, 3);

    done = 1;
    report();
  end
endmodule